// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core

This core keeps wall-clock time for a chip. A slow reference oscillator is seen on the system clock as a one-cycle enable pulse, `ref_tick`. A prescaler counts these pulses down to a one-second tick. The count limit comes from one of three reference rates, chosen by a field in the control register. Each tick advances a chain of counters for seconds, minutes, hours and days. The days counter has a width set by a parameter. A second set of registers holds an alarm time. The core gives a one-cycle alarm pulse on the tick that brings the running time equal to the alarm time.

Software uses a plain 16-bit register port. A write happens in any cycle with `bus_wr` high. A read is combinational from `bus_addr`. The core stays idle until software sets the enable bit in the control register. Software can read that bit back to confirm the core is running. Time and alarm values are set by writing their fields directly.

Top module: `rtc_core`

## Requirements
- R1: After reset every mapped register reads 0, the core is disabled, and `sec_pulse` and `alarm_pulse` are low.
- R2: The register offsets are: hour/minute at 0x00, seconds at 0x04, alarm hour/minute at 0x08, alarm seconds at 0x0C, control at 0x10, days at 0x20, and alarm days at 0x24. In both hour/minute registers, the hour is in bits 15:8 and the minute is in bits 7:0. A write keeps the low 5 hour bits (12:8), the low 6 minute bits, the low 6 seconds bits and the low DAY_W day bits. Reads zero-extend the stored value. Any other offset reads 0.
- R3: In the control register, bit 7 is the enable and bits 6:5 are the rate select. A read returns both fields as written, and every other bit reads 0.
- R4: While the core is enabled, the time advances by one second on every Nth reference pulse. N is RATE_A for select code 0, RATE_B for code 1, RATE_C for code 2, and RATE_A for code 3.
- R5: While the enable bit is 0, reference pulses have no effect on the time. The prescaler is cleared, so after the core is enabled again a full N pulses are needed for the next second.
- R6: Seconds and minutes go from 59 back to 0 and carry into the next field. Hours go from 23 back to 0 and carry into the days counter. Any stored value above its maximum also rolls to 0 on its next increment.
- R7: The days counter rolls from 2^DAY_W-1 to 0.
- R8: A write to the hour/minute, seconds or days register takes effect on the next clock edge and clears the prescaler. A reference pulse in the same cycle as the write does not advance the time.
- R9: `alarm_pulse` is high for one cycle, in the cycle that `sec_pulse` is high, if day, hour, minute and seconds all equal the alarm registers. A partial match gives no pulse, and writing an alarm equal to the current time gives no pulse by itself.
- R10: `sec_pulse` is high for exactly one cycle per second advanced. It is high in the first cycle in which the registers show the new time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse for each reference oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| sec_pulse | output | 1 | One-cycle pulse after each second advance |
| alarm_pulse | output | 1 | One-cycle pulse when the time reaches the alarm |

## Verification
Faults in the prescaler are seen at the first second boundary. An off-by-one count moves `sec_pulse` by a cycle against a model that counts reference pulses. A prescaler that was not cleared brings a second early after a time write or after the core is enabled again. A wrong carry in the counters is seen at the read port one cycle after the tick that crosses a field limit, and the bench places time values just below 59, 23 and the top day to reach these quickly. A wrong alarm compare shows as a missing or extra `alarm_pulse` on that same tick, and the bench includes alarms that differ in one field only.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
   localparam int SEC_W    = 6;
   localparam int MIN_W    = 6;
   localparam int HOUR_W   = 5;
   localparam int SEC_TOP  = 59;
   localparam int MIN_TOP  = 59;
   localparam int HOUR_TOP = 23;
   localparam int DATA_W   = 16;

   localparam int NREG = 7;
   localparam int IDX_HM   = 0;
   localparam int IDX_SEC  = 1;
   localparam int IDX_AHM  = 2;
   localparam int IDX_ASEC = 3;
   localparam int IDX_CTRL = 4;
   localparam int IDX_DAY  = 5;
   localparam int IDX_ADAY = 6;

   localparam logic [5:0] REG_OFS [NREG] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h20, 6'h24};

   localparam int CTRL_EN_BIT  = 7;
   localparam int CTRL_SEL_LSB = 5;

   typedef enum logic [1:0] {
      RATE_SEL_A   = 2'd0,
      RATE_SEL_B   = 2'd1,
      RATE_SEL_C   = 2'd2,
      RATE_SEL_ALT = 2'd3
   } rate_sel_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int RATE_A = 32768,
   parameter int RATE_B = 32000,
   parameter int RATE_C = 38400,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [1:0]       sel,
   input  logic             ref_tick,
   output logic             tick,
   output logic [CNT_W-1:0] cnt_q
);
   import rtc_core_pkg::*;

   logic [CNT_W-1:0] lim_m1;
   logic             at_top;

   always_comb begin
      unique case (rate_sel_e'(sel))
         RATE_SEL_B: lim_m1 = CNT_W'(RATE_B - 1);
         RATE_SEL_C: lim_m1 = CNT_W'(RATE_C - 1);
         default:    lim_m1 = CNT_W'(RATE_A - 1);
      endcase
   end

   assign at_top = (cnt_q >= lim_m1);
   assign tick   = en & ~clr & ref_tick & at_top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || clr) begin
         cnt_q <= '0;
      end else if (ref_tick) begin
         cnt_q <= at_top ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
   parameter int DAY_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick,
   input  logic                           wr_hm,
   input  logic                           wr_sec,
   input  logic                           wr_day,
   input  logic [rtc_core_pkg::HOUR_W-1:0] wr_hour_v,
   input  logic [rtc_core_pkg::MIN_W-1:0]  wr_min_v,
   input  logic [rtc_core_pkg::SEC_W-1:0]  wr_sec_v,
   input  logic [DAY_W-1:0]               wr_day_v,
   output logic [rtc_core_pkg::SEC_W-1:0]  sec_q,
   output logic [rtc_core_pkg::MIN_W-1:0]  min_q,
   output logic [rtc_core_pkg::HOUR_W-1:0] hour_q,
   output logic [DAY_W-1:0]               day_q,
   output logic                           sec_pulse
);
   import rtc_core_pkg::*;

   logic c_min, c_hour, c_day;

   assign c_min  = tick   & (sec_q  >= SEC_W'(SEC_TOP));
   assign c_hour = c_min  & (min_q  >= MIN_W'(MIN_TOP));
   assign c_day  = c_hour & (hour_q >= HOUR_W'(HOUR_TOP));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q     <= '0;
         min_q     <= '0;
         hour_q    <= '0;
         day_q     <= '0;
         sec_pulse <= 1'b0;
      end else begin
         sec_pulse <= tick;
         if (wr_sec)      sec_q <= wr_sec_v;
         else if (c_min)  sec_q <= '0;
         else if (tick)   sec_q <= sec_q + SEC_W'(1);

         if (wr_hm)       min_q <= wr_min_v;
         else if (c_hour) min_q <= '0;
         else if (c_min)  min_q <= min_q + MIN_W'(1);

         if (wr_hm)       hour_q <= wr_hour_v;
         else if (c_day)  hour_q <= '0;
         else if (c_hour) hour_q <= hour_q + HOUR_W'(1);

         if (wr_day)      day_q <= wr_day_v;
         else if (c_day)  day_q <= day_q + DAY_W'(1);
      end
   end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
   parameter int DAY_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_ahm,
   input  logic                           wr_asec,
   input  logic                           wr_aday,
   input  logic [rtc_core_pkg::HOUR_W-1:0] wr_hour_v,
   input  logic [rtc_core_pkg::MIN_W-1:0]  wr_min_v,
   input  logic [rtc_core_pkg::SEC_W-1:0]  wr_sec_v,
   input  logic [DAY_W-1:0]               wr_day_v,
   input  logic [rtc_core_pkg::SEC_W-1:0]  sec_v,
   input  logic [rtc_core_pkg::MIN_W-1:0]  min_v,
   input  logic [rtc_core_pkg::HOUR_W-1:0] hour_v,
   input  logic [DAY_W-1:0]               day_v,
   input  logic                           sec_pulse,
   output logic [rtc_core_pkg::SEC_W-1:0]  a_sec,
   output logic [rtc_core_pkg::MIN_W-1:0]  a_min,
   output logic [rtc_core_pkg::HOUR_W-1:0] a_hour,
   output logic [DAY_W-1:0]               a_day,
   output logic                           alarm_pulse
);
   logic [3:0] fld_eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_sec  <= '0;
         a_min  <= '0;
         a_hour <= '0;
         a_day  <= '0;
      end else begin
         if (wr_asec) a_sec <= wr_sec_v;
         if (wr_ahm) begin
            a_min  <= wr_min_v;
            a_hour <= wr_hour_v;
         end
         if (wr_aday) a_day <= wr_day_v;
      end
   end

   assign fld_eq[0] = (sec_v  == a_sec);
   assign fld_eq[1] = (min_v  == a_min);
   assign fld_eq[2] = (hour_v == a_hour);
   assign fld_eq[3] = (day_v  == a_day);

   assign alarm_pulse = sec_pulse & (&fld_eq);
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
   parameter int DAY_W  = 16,
   parameter int ADDR_W = 6,
   parameter int RATE_A = 32768,
   parameter int RATE_B = 32000,
   parameter int RATE_C = 38400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              sec_pulse,
   output logic              alarm_pulse
);
   import rtc_core_pkg::*;

   localparam int RATE_AB  = (RATE_A > RATE_B) ? RATE_A : RATE_B;
   localparam int RATE_MAX = (RATE_AB > RATE_C) ? RATE_AB : RATE_C;
   localparam int CNT_W    = $clog2(RATE_MAX);

   if (DAY_W < 1 || DAY_W > DATA_W) begin : g_bad_day
      $error("rtc_core: DAY_W out of range");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("rtc_core: ADDR_W too small for the register map");
   end
   if (RATE_A < 2 || RATE_B < 2 || RATE_C < 2) begin : g_bad_rate
      $error("rtc_core: every rate must be at least 2");
   end

   logic [NREG-1:0]   hit;
   logic [NREG-1:0]   wr_hit;
   logic [DATA_W-1:0] rd_word [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_dec
      assign hit[g]    = (bus_addr == ADDR_W'(REG_OFS[g]));
      assign wr_hit[g] = bus_wr & hit[g];
   end

   logic       ctrl_en;
   logic [1:0] ctrl_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         ctrl_sel <= '0;
      end else if (wr_hit[IDX_CTRL]) begin
         ctrl_en  <= bus_wdata[CTRL_EN_BIT];
         ctrl_sel <= bus_wdata[CTRL_SEL_LSB +: 2];
      end
   end

   logic time_wr;
   assign time_wr = wr_hit[IDX_HM] | wr_hit[IDX_SEC] | wr_hit[IDX_DAY];

   logic [HOUR_W-1:0] w_hour;
   logic [MIN_W-1:0]  w_min;
   logic [SEC_W-1:0]  w_sec;
   logic [DAY_W-1:0]  w_day;
   logic              unused_wdata;

   assign w_hour       = bus_wdata[8 +: HOUR_W];
   assign w_min        = bus_wdata[0 +: MIN_W];
   assign w_sec        = bus_wdata[0 +: SEC_W];
   assign w_day        = bus_wdata[0 +: DAY_W];
   assign unused_wdata = ^bus_wdata[15:13];

   logic             tick;
   logic [CNT_W-1:0] pre_cnt;

   rtc_prescaler #(
      .RATE_A(RATE_A), .RATE_B(RATE_B), .RATE_C(RATE_C), .CNT_W(CNT_W)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .clr(time_wr),
      .sel(ctrl_sel), .ref_tick(ref_tick), .tick(tick), .cnt_q(pre_cnt)
   );

   logic [SEC_W-1:0]  sec_v;
   logic [MIN_W-1:0]  min_v;
   logic [HOUR_W-1:0] hour_v;
   logic [DAY_W-1:0]  day_v;

   rtc_time_counter #(.DAY_W(DAY_W)) u_time (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wr_hm(wr_hit[IDX_HM]), .wr_sec(wr_hit[IDX_SEC]), .wr_day(wr_hit[IDX_DAY]),
      .wr_hour_v(w_hour), .wr_min_v(w_min), .wr_sec_v(w_sec), .wr_day_v(w_day),
      .sec_q(sec_v), .min_q(min_v), .hour_q(hour_v), .day_q(day_v),
      .sec_pulse(sec_pulse)
   );

   logic [SEC_W-1:0]  a_sec;
   logic [MIN_W-1:0]  a_min;
   logic [HOUR_W-1:0] a_hour;
   logic [DAY_W-1:0]  a_day;

   rtc_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
      .clk(clk), .rst_n(rst_n),
      .wr_ahm(wr_hit[IDX_AHM]), .wr_asec(wr_hit[IDX_ASEC]), .wr_aday(wr_hit[IDX_ADAY]),
      .wr_hour_v(w_hour), .wr_min_v(w_min), .wr_sec_v(w_sec), .wr_day_v(w_day),
      .sec_v(sec_v), .min_v(min_v), .hour_v(hour_v), .day_v(day_v),
      .sec_pulse(sec_pulse),
      .a_sec(a_sec), .a_min(a_min), .a_hour(a_hour), .a_day(a_day),
      .alarm_pulse(alarm_pulse)
   );

   assign rd_word[IDX_HM]   = (DATA_W'(hour_v) << 8) | DATA_W'(min_v);
   assign rd_word[IDX_SEC]  = DATA_W'(sec_v);
   assign rd_word[IDX_AHM]  = (DATA_W'(a_hour) << 8) | DATA_W'(a_min);
   assign rd_word[IDX_ASEC] = DATA_W'(a_sec);
   assign rd_word[IDX_CTRL] = (DATA_W'(ctrl_en) << CTRL_EN_BIT) | (DATA_W'(ctrl_sel) << CTRL_SEL_LSB);
   assign rd_word[IDX_DAY]  = DATA_W'(day_v);
   assign rd_word[IDX_ADAY] = DATA_W'(a_day);

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) bus_rdata = bus_rdata | rd_word[i];
      end
   end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
   parameter int CNT_W = 16,
   parameter int SEC_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             time_wr,
   input logic [CNT_W-1:0] pre_cnt,
   input logic [SEC_W-1:0] sec_v,
   input logic             sec_pulse,
   input logic             alarm_pulse
);
   // R10
   sec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse);

   // R9
   alarm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> sec_pulse);

   // R5
   idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sec_pulse);

   // R5
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pre_cnt == '0));

   // R8
   write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr |=> (pre_cnt == '0));

   // R6
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> ((sec_v == '0) || (sec_v == $past(sec_v) + SEC_W'(1))));
endmodule

bind rtc_core rtc_core_chk #(.CNT_W(CNT_W), .SEC_W(rtc_core_pkg::SEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl_en), .time_wr(time_wr), .pre_cnt(pre_cnt),
   .sec_v(sec_v), .sec_pulse(sec_pulse), .alarm_pulse(alarm_pulse)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
   localparam int DAY_W = 9;
   localparam int RA = 4, RB = 3, RC = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        sec_pulse, alarm_pulse;

   rtc_core #(.DAY_W(DAY_W), .ADDR_W(6), .RATE_A(RA), .RATE_B(RB), .RATE_C(RC)) dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sec_pulse(sec_pulse), .alarm_pulse(alarm_pulse)
   );

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int sec_seen = 0, alarm_seen = 0;
   bit done = 0, rnd_ref = 0;

   // behavioural reference model
   int m_en, m_sel, m_cnt, m_sec, m_min, m_hour, m_day, m_pulse;
   int a_sec, a_min, a_hour, a_day;

   function automatic int exp_rd(int a);
      case (a)
         'h00: return m_hour * 256 + m_min;
         'h04: return m_sec;
         'h08: return a_hour * 256 + a_min;
         'h0C: return a_sec;
         'h10: return m_en * 128 + m_sel * 32;
         'h20: return m_day;
         'h24: return a_day;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_sel = 0; m_cnt = 0; m_pulse = 0;
         m_sec = 0; m_min = 0; m_hour = 0; m_day = 0;
         a_sec = 0; a_min = 0; a_hour = 0; a_day = 0;
      end else begin
         int lim, d, a;
         bit twr, tk;
         d = bus_wdata; a = bus_addr;
         lim = (m_sel == 1) ? RB : (m_sel == 2) ? RC : RA;
         twr = bus_wr && (a == 'h00 || a == 'h04 || a == 'h20);
         tk = m_en && ref_tick && !twr && (m_cnt >= lim - 1);
         if (!m_en || twr) m_cnt = 0;
         else if (ref_tick) m_cnt = (m_cnt >= lim - 1) ? 0 : m_cnt + 1;
         if (tk) begin
            if (m_sec >= 59) begin
               m_sec = 0;
               if (m_min >= 59) begin
                  m_min = 0;
                  if (m_hour >= 23) begin
                     m_hour = 0;
                     m_day = (m_day + 1) % (1 << DAY_W);
                  end else m_hour++;
               end else m_min++;
            end else m_sec++;
         end
         if (bus_wr) begin
            case (a)
               'h00: begin m_hour = (d >> 8) & 31; m_min = d & 63; end
               'h04: m_sec = d & 63;
               'h08: begin a_hour = (d >> 8) & 31; a_min = d & 63; end
               'h0C: a_sec = d & 63;
               'h10: begin m_en = (d >> 7) & 1; m_sel = (d >> 5) & 3; end
               'h20: m_day = d & ((1 << DAY_W) - 1);
               'h24: a_day = d & ((1 << DAY_W) - 1);
               default: ;
            endcase
         end
         m_pulse = tk;
      end
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model, away from the sampling edge
   always @(posedge clk) begin
      cyc++;
      #1;
      if (rst_n) begin
         int ea;
         ea = m_pulse && m_sec == a_sec && m_min == a_min && m_hour == a_hour && m_day == a_day;
         check("R10 sec_pulse", int'(sec_pulse), m_pulse);
         check("R9 alarm_pulse", int'(alarm_pulse), ea);
         check("R2 rdata", int'(bus_rdata), exp_rd(bus_addr));
         if (sec_pulse) sec_seen++;
         if (alarm_pulse) alarm_seen++;
      end
      if (cyc > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   always @(negedge clk) if (rnd_ref) ref_tick <= ($urandom % 2 == 0);

   task automatic wr(int a, int d);
      @(negedge clk); bus_wr = 1; bus_addr = 6'(a); bus_wdata = 16'(d);
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic wr_ref(int a, int d);
      @(negedge clk); bus_wr = 1; bus_addr = 6'(a); bus_wdata = 16'(d); ref_tick = 1;
      @(negedge clk); bus_wr = 0; ref_tick = 0;
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1;
         @(negedge clk); ref_tick = 0;
      end
   endtask

   task automatic rd(int a, output int v);
      @(negedge clk); bus_addr = 6'(a);
      @(posedge clk); #1; v = bus_rdata;
   endtask

   task automatic rd_chk(string req, int a, int exp);
      int v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      int lims[4];
      lims = '{RA, RB, RC, RA};
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state and R2 unmapped offset
      for (int i = 0; i < 7; i++) begin
         int offs[7];
         offs = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h20, 'h24};
         rd_chk("R1 reset reg", offs[i], 0);
      end
      rd_chk("R2 unmapped", 'h14, 0);
      check("R1 sec_pulse", int'(sec_pulse), 0);
      // R3 control read-back
      wr('h10, 'hFFFF);
      rd_chk("R3 ctrl", 'h10, 'h00E0);
      // R4 rate select
      for (int s = 0; s < 4; s++) begin
         wr('h10, 'h80 | (s << 5));
         wr('h04, 0);
         pulses(lims[s] - 1);
         rd_chk("R4 before limit", 'h04, 0);
         pulses(1);
         rd_chk("R4 at limit", 'h04, 1);
      end
      // R5 disable
      wr('h10, 'h80);
      wr('h04, 0);
      pulses(2);
      wr('h10, 'h00);
      pulses(10);
      rd_chk("R5 disabled hold", 'h04, 0);
      wr('h10, 'h80);
      pulses(3);
      rd_chk("R5 prescaler cleared", 'h04, 0);
      pulses(1);
      rd_chk("R5 full second", 'h04, 1);
      // R6 carries
      wr('h04, 58); wr('h00, 'h003B); wr('h20, 5);
      pulses(4);
      rd_chk("R6 sec 59", 'h04, 59);
      pulses(4);
      rd_chk("R6 sec wrap", 'h04, 0);
      rd_chk("R6 min carry", 'h00, 'h0100);
      wr('h04, 59); wr('h00, 'h173B);
      pulses(4);
      rd_chk("R6 hour wrap", 'h00, 0);
      rd_chk("R6 day carry", 'h20, 6);
      // R7 day wrap and R2 truncation
      wr('h20, 'hFFFF);
      rd_chk("R2 day truncate", 'h20, 'h01FF);
      wr('h04, 59); wr('h00, 'h173B);
      pulses(4);
      rd_chk("R7 day wrap", 'h20, 0);
      // R8 writes clear prescaler
      wr('h04, 10);
      pulses(2);
      wr('h04, 20);
      pulses(3);
      rd_chk("R8 cleared", 'h04, 20);
      pulses(1);
      rd_chk("R8 full", 'h04, 21);
      pulses(3);
      wr_ref('h04, 30);
      rd_chk("R8 write wins", 'h04, 30);
      pulses(3);
      rd_chk("R8 after write", 'h04, 30);
      pulses(1);
      rd_chk("R8 next second", 'h04, 31);
      // R9 alarm
      wr('h24, 2); wr('h08, 'h0102); wr('h0C, 5);
      wr('h20, 2); wr('h00, 'h0102); wr('h04, 3);
      alarm_seen = 0;
      pulses(8);
      rd_chk("R9 reached", 'h04, 5);
      check("R9 one alarm", alarm_seen, 1);
      pulses(8);
      check("R9 no repeat", alarm_seen, 1);
      wr('h24, 3); wr('h04, 3);
      pulses(8);
      check("R9 partial match", alarm_seen, 1);
      wr('h24, 2);
      repeat (4) @(negedge clk);
      check("R9 alarm write only", alarm_seen, 1);
      // R10 pulse count
      wr('h04, 0);
      sec_seen = 0;
      pulses(40);
      repeat (2) @(negedge clk);
      check("R10 pulse count", sec_seen, 10);
      rd_chk("R10 seconds", 'h04, 10);
      // random phase: model comparison every cycle
      rnd_ref = 1;
      for (int i = 0; i < 1500; i++) begin
         int offs[7];
         offs = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h20, 'h24};
         @(negedge clk);
         bus_addr = 6'(offs[$urandom % 7]);
         if ($urandom % 16 == 0) begin
            bus_wr = 1;
            bus_wdata = (bus_addr == 'h10) ? 16'('h80 | (($urandom % 4) << 5)) : 16'($urandom);
         end else bus_wr = 0;
      end
      @(negedge clk); bus_wr = 0; rnd_ref = 0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule